// File: doc/BRIEF.md
# Display Command Target on a Two-Wire Bus

This block is the bus-facing front end of a character display controller. It listens to the two-wire serial bus (clock and data lines, open-drain), oversamples both lines with the system clock, and recognises START and STOP. When a transfer names its own 7-bit address, it acknowledges the address and every byte it receives. It then splits the byte stream into control bytes and payload. Each payload byte reaches the display core as a one-cycle strobe, either as a command or as RAM data.

A control byte carries two flags. Bit 7 is the continuation flag: while it is 1, each control byte is followed by exactly one payload byte, and then another control byte is expected. Once a control byte arrives with bit 7 clear, every byte up to the next START or STOP is payload. Bit 6 selects the destination of that payload: 1 for RAM data, 0 for the command decoder. The most recent bit-6 value also selects what a read transfer returns: the core's status byte (busy flag and address counter) or RAM data from the core. When a RAM byte is loaded for transmission, the block pulses a take strobe toward the core.

The data line is driven only through `sda_oe`. When it is 1, the pad pulls the line low; when it is 0, the line is released.

Top module: `i2c_disp_target`

## Requirements
- R1: The own address is 7'b0111100 when `addr_sel` is 0 and 7'b0111101 when it is 1. The byte after START holds the address in bits 7..1 and the direction bit in bit 0 (0 = write, 1 = read). A matching address is acknowledged by holding `sda_oe` high through the ninth clock pulse.
- R2: After a non-matching address, `sda_oe` stays 0 and no strobe is produced until the next START.
- R3: While a control byte has bit 7 set, exactly one payload byte follows it, and the byte after that payload is again parsed as a control byte.
- R4: After a control byte with bit 7 clear, every byte until STOP or START is payload, including bytes whose bit 7 is set.
- R5: Payload goes to `data_valid`/`data_byte` when bit 6 of the governing control byte is 1, and to `cmd_valid`/`cmd_byte` when it is 0. Control bytes themselves raise neither strobe, and the two strobes are never high together.
- R6: Every byte received in a write transfer addressed to this block is acknowledged on the ninth pulse, and `sda_oe` stays 0 during its eight data bits. Each payload strobe lasts one cycle and comes only after the acknowledge clock falls.
- R7: In a read transfer, the transmitted bytes (MSB first) are `status_byte` when the last bit 6 received was 0, and `rd_data` when it was 1. In the RAM case, `rd_take` pulses once for each byte loaded into the shifter.
- R8: When the master does not acknowledge a read byte, `sda_oe` is released, and stays released through any further clock pulses until the next START.
- R9: A START inside a transfer, including in the middle of a byte, discards the partial byte and returns to address reception. The next write transfer again begins with a control byte.
- R10: A pulse of 2 or fewer system-clock samples on either bus line is ignored. It produces no START, STOP or extra bit.
- R11: `sda_oe` changes only while the filtered clock line is low, except when a START or STOP releases it.
- R12: After reset, `sda_oe`, `cmd_valid`, `data_valid` and `rd_take` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Selects the low bit of the own address |
| status_byte | input | 8 | Busy flag and address counter from the core, returned on reads |
| rd_data | input | 8 | RAM byte from the core, returned on reads |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_valid | output | 1 | One-cycle strobe for a command payload byte |
| cmd_byte | output | 8 | Command payload byte |
| data_valid | output | 1 | One-cycle strobe for a RAM payload byte |
| data_byte | output | 8 | RAM payload byte |
| rd_take | output | 1 | Pulses when a RAM byte is loaded for transmission |

## Verification
Two framing decisions can land on the same byte boundary: the last payload byte of a continuation pair and the control byte that follows it. The bench makes them abut by sending bytes back to back, with alternating flag bits in one transfer, so a wrong return to control parsing sends a byte to the wrong strobe. A second coincidence is a START arriving while a byte is half shifted. The bench provokes it after three data bits, then judges from the next transaction's routing that the partial byte never reached either stream. Bus glitches are injected while a real data bit is held, and the result is judged by the byte value that finally reaches the core.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [1:0] {
        L_IDLE,
        L_ADDR,
        L_WR,
        L_RD
    } link_st_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_CTRL,
        F_ONE,
        F_STREAM
    } frame_st_e;

    localparam int BYTE_W = 8;
    localparam int CO_POS = 7;
    localparam int DC_POS = 6;

endpackage

// File: rtl/i2ct_deglitch.sv
module i2ct_deglitch #(
    parameter int  FILT_LEN = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    typedef struct packed {
        logic [1:0]          sync;
        logic [FILT_LEN-1:0] hist;
        logic                clean;
    } dg_t;

    dg_t dg_d, dg_q;

    always_comb begin
        dg_d       = dg_q;
        dg_d.sync  = {dg_q.sync[0], raw_i};
        dg_d.hist  = {dg_q.hist[FILT_LEN-2:0], dg_q.sync[1]};
        if (&dg_q.hist) begin
            dg_d.clean = 1'b1;
        end else if (~|dg_q.hist) begin
            dg_d.clean = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dg_q <= '{sync: {2{RST_VAL}}, hist: {FILT_LEN{RST_VAL}}, clean: RST_VAL};
        end else begin
            dg_q <= dg_d;
        end
    end

    assign clean_o = dg_q.clean;

    // The filtered level only moves to a value the synchroniser delivered earlier.
    AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dg_q.clean) |-> ($past(dg_q.sync[1], 2) == dg_q.clean)); // R10

endmodule

// File: rtl/i2ct_bitlink.sv
module i2ct_bitlink
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [6:0]        my_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_o,
    output logic              txn_wr,
    output logic              bus_rst,
    output logic              tx_load
);

    typedef struct packed {
        link_st_e          st;
        logic [3:0]        cnt;
        logic              in_ack;
        logic              nack;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] byte_val;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
        logic              byte_stb;
        logic              txn_wr;
        logic              bus_rst;
        logic              tx_load;
    } lk_t;

    lk_t lk_d, lk_q;
    logic rise, fall, start_c, stop_c;

    always_comb begin
        rise    = scl_f & ~lk_q.scl_p;
        fall    = ~scl_f & lk_q.scl_p;
        start_c = scl_f & lk_q.scl_p & lk_q.sda_p & ~sda_f;
        stop_c  = scl_f & lk_q.scl_p & ~lk_q.sda_p & sda_f;

        lk_d          = lk_q;
        lk_d.scl_p    = scl_f;
        lk_d.sda_p    = sda_f;
        lk_d.byte_stb = 1'b0;
        lk_d.txn_wr   = 1'b0;
        lk_d.bus_rst  = 1'b0;
        lk_d.tx_load  = 1'b0;

        if (start_c) begin
            lk_d.st      = L_ADDR;
            lk_d.cnt     = '0;
            lk_d.in_ack  = 1'b0;
            lk_d.oe      = 1'b0;
            lk_d.bus_rst = 1'b1;
        end else if (stop_c) begin
            lk_d.st      = L_IDLE;
            lk_d.cnt     = '0;
            lk_d.in_ack  = 1'b0;
            lk_d.oe      = 1'b0;
            lk_d.bus_rst = 1'b1;
        end else begin
            case (lk_q.st)
                L_ADDR, L_WR: begin
                    if (rise && !lk_q.in_ack && lk_q.cnt < 4'd8) begin
                        lk_d.sh  = {lk_q.sh[BYTE_W-2:0], sda_f};
                        lk_d.cnt = lk_q.cnt + 4'd1;
                    end
                    if (fall) begin
                        if (!lk_q.in_ack && lk_q.cnt == 4'd8) begin
                            lk_d.in_ack = 1'b1;
                            if (lk_q.st == L_ADDR) begin
                                if (lk_q.sh[7:1] == my_addr) begin
                                    lk_d.oe = 1'b1;
                                end else begin
                                    lk_d.st     = L_IDLE;
                                    lk_d.in_ack = 1'b0;
                                end
                            end else begin
                                lk_d.oe = 1'b1;
                            end
                        end else if (lk_q.in_ack) begin
                            lk_d.in_ack = 1'b0;
                            lk_d.oe     = 1'b0;
                            lk_d.cnt    = '0;
                            if (lk_q.st == L_WR) begin
                                lk_d.byte_stb = 1'b1;
                                lk_d.byte_val = lk_q.sh;
                            end else if (lk_q.sh[0]) begin
                                lk_d.st      = L_RD;
                                lk_d.tx      = tx_byte;
                                lk_d.oe      = ~tx_byte[7];
                                lk_d.tx_load = 1'b1;
                            end else begin
                                lk_d.st     = L_WR;
                                lk_d.txn_wr = 1'b1;
                            end
                        end
                    end
                end
                L_RD: begin
                    if (rise) begin
                        if (lk_q.in_ack) begin
                            lk_d.nack = sda_f;
                        end else if (lk_q.cnt < 4'd8) begin
                            lk_d.cnt = lk_q.cnt + 4'd1;
                        end
                    end
                    if (fall) begin
                        if (lk_q.in_ack) begin
                            lk_d.in_ack = 1'b0;
                            lk_d.cnt    = '0;
                            if (lk_q.nack) begin
                                lk_d.st = L_IDLE;
                                lk_d.oe = 1'b0;
                            end else begin
                                lk_d.tx      = tx_byte;
                                lk_d.oe      = ~tx_byte[7];
                                lk_d.tx_load = 1'b1;
                            end
                        end else if (lk_q.cnt == 4'd8) begin
                            lk_d.oe     = 1'b0;
                            lk_d.in_ack = 1'b1;
                        end else if (lk_q.cnt != 4'd0) begin
                            lk_d.oe = ~lk_q.tx[3'd7 - lk_q.cnt[2:0]];
                        end
                    end
                end
                default: begin
                    lk_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '{st: L_IDLE, cnt: '0, in_ack: 1'b0, nack: 1'b0, sh: '0, tx: '0,
                      byte_val: '0, oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1, byte_stb: 1'b0,
                      txn_wr: 1'b0, bus_rst: 1'b0, tx_load: 1'b0};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign sda_oe   = lk_q.oe;
    assign byte_stb = lk_q.byte_stb;
    assign byte_o   = lk_q.byte_val;
    assign txn_wr   = lk_q.txn_wr;
    assign bus_rst  = lk_q.bus_rst;
    assign tx_load  = lk_q.tx_load;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.st == L_IDLE) |-> !lk_q.oe); // R8

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lk_q.oe) && !lk_q.bus_rst) |-> !scl_f); // R11

    AST_WR_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.st == L_WR && !lk_q.in_ack) |-> !lk_q.oe); // R6

endmodule

// File: rtl/i2ct_framer.sv
module i2ct_framer
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              txn_wr,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              dc_o,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte
);

    typedef struct packed {
        frame_st_e         st;
        logic              dc;
        logic              cmd_v;
        logic [BYTE_W-1:0] cmd_b;
        logic              dat_v;
        logic [BYTE_W-1:0] dat_b;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d       = fr_q;
        fr_d.cmd_v = 1'b0;
        fr_d.dat_v = 1'b0;
        if (bus_rst) begin
            fr_d.st = F_IDLE;
        end else if (txn_wr) begin
            fr_d.st = F_CTRL;
        end else if (byte_stb) begin
            case (fr_q.st)
                F_CTRL: begin
                    fr_d.dc = byte_i[DC_POS];
                    fr_d.st = byte_i[CO_POS] ? F_ONE : F_STREAM;
                end
                F_ONE, F_STREAM: begin
                    if (fr_q.dc) begin
                        fr_d.dat_v = 1'b1;
                        fr_d.dat_b = byte_i;
                    end else begin
                        fr_d.cmd_v = 1'b1;
                        fr_d.cmd_b = byte_i;
                    end
                    if (fr_q.st == F_ONE) begin
                        fr_d.st = F_CTRL;
                    end
                end
                default: fr_d.st = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: F_IDLE, dc: 1'b0, cmd_v: 1'b0, cmd_b: '0, dat_v: 1'b0, dat_b: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign dc_o       = fr_q.dc;
    assign cmd_valid  = fr_q.cmd_v;
    assign cmd_byte   = fr_q.cmd_b;
    assign data_valid = fr_q.dat_v;
    assign data_byte  = fr_q.dat_b;

    AST_CTRL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && fr_q.st == F_CTRL && !bus_rst && !txn_wr) |=> !(cmd_valid || data_valid)); // R5

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, data_valid})); // R5

    AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || data_valid) |=> !(cmd_valid || data_valid)); // R6

endmodule

// File: rtl/i2c_disp_target.sv
module i2c_disp_target
    import i2ct_pkg::*;
#(
    parameter logic [5:0] ADDR_HI  = 6'b011110,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte,
    output logic              rd_take
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic [6:0]         my_addr;
    logic [BYTE_W-1:0]  tx_byte;
    logic [BYTE_W-1:0]  rx_byte;
    logic               byte_stb, txn_wr, bus_rst, tx_load, dc;

    assign raw_lines = {sda_i, scl_i};
    assign my_addr   = {ADDR_HI, addr_sel};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2ct_deglitch #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (1'b1)
        ) u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    assign tx_byte = dc ? rd_data : status_byte;
    assign rd_take = tx_load & dc;

    i2ct_bitlink u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (clean_lines[0]),
        .sda_f    (clean_lines[1]),
        .my_addr  (my_addr),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .byte_stb (byte_stb),
        .byte_o   (rx_byte),
        .txn_wr   (txn_wr),
        .bus_rst  (bus_rst),
        .tx_load  (tx_load)
    );

    i2ct_framer u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .txn_wr     (txn_wr),
        .byte_stb   (byte_stb),
        .byte_i     (rx_byte),
        .dc_o       (dc),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .data_valid (data_valid),
        .data_byte  (data_byte)
    );

endmodule

// File: tb/i2c_disp_target_bench.sv
`timescale 1ns/1ps
module i2c_disp_target_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] status_byte = 8'hA5;
    logic [7:0] rd_data = 8'h3C;
    logic       sda_oe, cmd_valid, data_valid, rd_take;
    logic [7:0] cmd_byte, data_byte;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int takes = 0;
    int scl_hi = 0;
    logic oe_prev = 1'b0;
    logic cv_prev = 1'b0;
    logic dv_prev = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_cmd[$];
    logic [7:0] exp_dat[$];

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_disp_target u_i2c_disp_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .addr_sel    (addr_sel),
        .status_byte (status_byte),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .data_valid  (data_valid),
        .data_byte   (data_byte),
        .rd_take     (rd_take)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference monitor, evaluated every clock away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                strobes++;
                if (exp_cmd.size() == 0) chk(0, "R5 unexpected cmd", cmd_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_cmd.pop_front();
                    chk(cmd_byte == e, "R5 cmd_byte", cmd_byte, e);
                end
            end
            if (data_valid) begin
                strobes++;
                if (exp_dat.size() == 0) chk(0, "R5 unexpected data", data_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_dat.pop_front();
                    chk(data_byte == e, "R5 data_byte", data_byte, e);
                end
            end
            if ((cmd_valid && cv_prev) || (data_valid && dv_prev))
                chk(0, "R6 strobe longer than one cycle", 1, 0);
            if (rd_take) takes++;
            if (scl_hi > 8 && sda_oe != oe_prev)
                chk(0, "R11 sda_oe moved while SCL high", sda_oe, oe_prev);
            scl_hi  = m_scl ? scl_hi + 1 : 0;
            oe_prev = sda_oe;
            cv_prev = cmd_valid;
            dv_prev = data_valid;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wait_n(20);
        m_sda = 1'b0; wait_n(20);
        m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_n(5); m_sda = 1'b1; wait_n(15);
        m_scl = 1'b1; wait_n(20);
        m_sda = 1'b0; wait_n(20);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(5); m_sda = 1'b0; wait_n(15);
        m_scl = 1'b1; wait_n(20);
        m_sda = 1'b1; wait_n(20);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            wait_n(5); m_sda = b[i];
            if (glitch && i == 2) begin
                wait_n(5); m_scl = 1'b1; wait_n(2); m_scl = 1'b0; wait_n(8);
            end else begin
                wait_n(15);
            end
            m_scl = 1'b1;
            if (glitch && i == 4) begin
                wait_n(8); m_sda = ~b[i]; wait_n(2); m_sda = b[i]; wait_n(10);
            end else begin
                wait_n(20);
            end
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                             input bit glitch);
        int s0;
        s0 = strobes;
        send_bits(b, 8, glitch);
        wait_n(5); m_sda = 1'b1; wait_n(15);
        m_scl = 1'b1; wait_n(12);
        chk(sda_oe == exp_ack, req, sda_oe, exp_ack);
        chk(strobes == s0, "R6 strobe before ack clock fell", strobes, s0);
        wait_n(8); m_scl = 1'b0;
        wait_n(12);
    endtask

    task automatic read_byte(input bit m_ack, input logic [7:0] exp, input string req);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            wait_n(5); m_sda = 1'b1; wait_n(15);
            m_scl = 1'b1; wait_n(12);
            got[i] = sda_bus;
            wait_n(8); m_scl = 1'b0;
        end
        chk(got == exp, req, got, exp);
        wait_n(5); m_sda = m_ack ? 1'b0 : 1'b1; wait_n(15);
        m_scl = 1'b1; wait_n(12);
        chk(sda_oe == 1'b0, "R8 released in master ack slot", sda_oe, 0);
        wait_n(8); m_scl = 1'b0;
        wait_n(2); m_sda = 1'b1;
    endtask

    initial begin
        wait_n(4);
        chk(sda_oe == 0 && cmd_valid == 0 && data_valid == 0 && rd_take == 0,
            "R12 reset outputs", {sda_oe, cmd_valid, data_valid, rd_take}, 0);
        rst_n = 1'b1;
        wait_n(10);

        // R1 address 0x3C write, R3 continuation pairs, R4 stream with bit 7 set
        bus_start();
        send_byte(8'h78, 1, "R1 address ack sel=0", 0);
        send_byte(8'h80, 1, "R6 ctrl ack", 0);
        exp_cmd.push_back(8'h38);
        send_byte(8'h38, 1, "R3 cmd after Co=1", 0);
        send_byte(8'hC0, 1, "R3 ctrl follows single payload", 0);
        exp_dat.push_back(8'h41);
        send_byte(8'h41, 1, "R3 data after Co=1", 0);
        send_byte(8'h40, 1, "R4 last ctrl", 0);
        exp_dat.push_back(8'h42); send_byte(8'h42, 1, "R4 stream byte", 0);
        exp_dat.push_back(8'h80); send_byte(8'h80, 1, "R4 stream byte with bit7", 0);
        exp_dat.push_back(8'hC3); send_byte(8'hC3, 1, "R4 stream byte with bits7,6", 0);
        bus_stop();
        chk(exp_dat.size() == 0 && exp_cmd.size() == 0, "R4 all payload delivered",
            exp_dat.size() + exp_cmd.size(), 0);

        // R5 command stream
        bus_start();
        send_byte(8'h78, 1, "R1 address ack", 0);
        send_byte(8'h00, 1, "R5 ctrl dc=0", 0);
        exp_cmd.push_back(8'hC0); send_byte(8'hC0, 1, "R5 cmd stream", 0);
        exp_cmd.push_back(8'h01); send_byte(8'h01, 1, "R5 cmd stream", 0);
        bus_stop();

        // R2 foreign address then R1 with sel=1
        bus_start();
        send_byte(8'h7A, 0, "R2 no ack foreign address", 0);
        send_byte(8'h00, 0, "R2 no ack after foreign", 0);
        send_byte(8'h55, 0, "R2 no ack after foreign", 0);
        bus_stop();
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h78, 0, "R1 old address rejected sel=1", 0);
        bus_stop();
        bus_start();
        send_byte(8'h7A, 1, "R1 address ack sel=1", 0);
        send_byte(8'h80, 1, "R6 ctrl ack", 0);
        exp_cmd.push_back(8'h0C); send_byte(8'h0C, 1, "R5 cmd", 0);
        bus_stop();

        // R9 repeated START mid-byte
        bus_start();
        send_byte(8'h7A, 1, "R1 address ack", 0);
        send_byte(8'h40, 1, "R6 ctrl ack", 0);
        exp_dat.push_back(8'h11); send_byte(8'h11, 1, "R9 data before restart", 0);
        send_bits(8'hE0, 3, 0);
        bus_rstart();
        send_byte(8'h7A, 1, "R9 address after restart", 0);
        send_byte(8'h00, 1, "R9 first byte parsed as ctrl", 0);
        exp_cmd.push_back(8'h22); send_byte(8'h22, 1, "R9 cmd after restart", 0);
        bus_stop();

        // R10 glitches on both lines inside a data byte
        bus_start();
        send_byte(8'h7A, 1, "R1 address ack", 0);
        send_byte(8'h40, 1, "R6 ctrl ack", 0);
        exp_dat.push_back(8'h5A); send_byte(8'h5A, 1, "R10 glitched byte ack", 1);
        bus_stop();
        chk(exp_dat.size() == 0, "R10 glitched byte delivered intact", exp_dat.size(), 0);

        // R7 status read, R8 nack
        bus_start();
        send_byte(8'h7A, 1, "R1 address ack", 0);
        send_byte(8'h00, 1, "R7 ctrl dc=0", 0);
        bus_stop();
        takes = 0;
        bus_start();
        send_byte(8'h7B, 1, "R1 read address ack", 0);
        read_byte(1, 8'hA5, "R7 status byte 1");
        read_byte(0, 8'hA5, "R7 status byte 2");
        read_byte(0, 8'hFF, "R8 released after nack");
        bus_stop();
        chk(takes == 0, "R7 no rd_take for status", takes, 0);

        // R7 RAM read
        bus_start();
        send_byte(8'h7A, 1, "R1 address ack", 0);
        send_byte(8'h40, 1, "R7 ctrl dc=1", 0);
        bus_stop();
        takes = 0;
        bus_start();
        send_byte(8'h7B, 1, "R1 read address ack", 0);
        read_byte(1, 8'h3C, "R7 ram byte 1");
        rd_data = 8'h96;
        read_byte(0, 8'h96, "R7 ram byte 2");
        read_byte(0, 8'hFF, "R8 released after nack");
        bus_stop();
        chk(takes == 2, "R7 rd_take per loaded byte", takes, 2);

        wait_n(20);
        chk(exp_cmd.size() == 0 && exp_dat.size() == 0, "R5 no missing strobes",
            exp_cmd.size() + exp_dat.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule